// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer sits between a host FIFO of 32-bit command words and the drawing pipeline. It reads the opcode in the top byte of the first word of each packet and looks up how many parameter words follow. It collects the whole packet in a small internal buffer. Once the final word has arrived, it sends the packet out on a valid/ready renderer port and marks the final word with a last flag.

While a packet is being collected, the framer also watches for state-setting opcodes and keeps their first words in eight shadow registers. It takes the texture-page bits from textured primitives and maintains a 13-bit status word built from two of those registers. Image transfer opcodes (0xA0 write, 0xC0 read) are not forwarded. Their position and size words go to a separate transfer engine through a one-cycle start strobe. The framer then accepts no input until that engine reports it is idle. A one-cycle dirty strobe flags each packet that can alter the frame buffer.

Top module: `gpf_framer`

## Requirements
- R1: The opcode is `in_data[31:24]` of the first word of a packet. Every word of a non-transfer packet leaves on `out_data` in arrival order, and `out_last` is high only on the final word.
- R2: A packet holds 1 + N words, where N depends on the opcode:
  - 0x02, 0xA0 and 0xC0: N = 2
  - 0x80: N = 3
  - 0x20–0x23: 3
  - 0x24–0x27: 6
  - 0x28–0x2B: 4
  - 0x2C–0x2F: 8
  - 0x30–0x33: 5
  - 0x34–0x37: 8
  - 0x38–0x3B: 7
  - 0x3C–0x3F: 11
  - 0x40–0x47: 2
  - 0x48–0x57: 3
  - 0x58–0x5F: 4
  - 0x60–0x63: 2
  - 0x64–0x67: 3
  - 0x68–0x6B: 1
  - 0x70–0x73: 1
  - 0x74–0x77: 2
  - 0x78–0x7B: 1
  - 0x7C–0x7F: 2
  - every other opcode: N = 0
- R3: `in_ready` is high while a packet is still being collected, including between its words. It is low from the clock edge that accepts a packet's final word until the edge that hands off that packet's last output word. While `in_ready` is high, `out_valid` is low.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R5: A packet with an opcode from 0xE0 to 0xE7 copies its whole first word into shadow register `opcode[2:0]`. `shadow_regs[32*i +: 32]` presents register i. Status bits 10:0 equal shadow register 1 bits 10:0, and status bits 12:11 equal shadow register 6 bits 1:0.
- R6: The texture-page snoop depends on the opcode:
  - When (opcode & 0xF4) == 0x24, bits 8:0 of shadow register 1 are replaced by bits 8:0 of parameter word 4, which is word index 4 counting the first word as 0.
  - When (opcode & 0xF4) == 0x34, parameter word 5 is used instead.
  - All other bits of the register are kept.
- R7: A packet with opcode 0xA0 or 0xC0 is not forwarded. After its third word, `xfer_start` is high for exactly one cycle. In that cycle, `xfer_pos` holds word 1, `xfer_size` holds word 2, and `xfer_read` is 1 for 0xC0 and 0 for 0xA0. `in_ready` stays low until the first cycle after `xfer_start` in which `xfer_busy` is low, and rises one clock edge later.
- R8: `frame_dirty` is high for exactly one cycle after the final word of any packet whose opcode lies in 0x02..0xBF is accepted, and is low otherwise.
- R9: After reset, shadow register i holds (0xE0 + i) << 24, so the status word is 0. At the same time `in_ready` = 1 and `out_valid`, `xfer_start` and `frame_dirty` are 0.
- R10: The shadow registers, the status word and `frame_dirty` change at the clock edge that accepts a packet's final word, and at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word available from the host FIFO |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Framer accepts a word this cycle |
| out_valid | output | 1 | Renderer word valid |
| out_data | output | 32 | Renderer word |
| out_last | output | 1 | Final word of the packet |
| out_ready | input | 1 | Renderer accepts the word |
| xfer_start | output | 1 | One-cycle image transfer start strobe |
| xfer_read | output | 1 | 1 = read from video memory, 0 = write |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_busy | input | 1 | Transfer engine is running |
| status | output | 13 | Status bits rebuilt from shadow registers 1 and 6 |
| shadow_regs | output | 256 | Eight 32-bit shadow registers, register i at bits 32*i+31:32*i |
| frame_dirty | output | 1 | One-cycle strobe for a frame-buffer-altering packet |

## Verification
The hardest case to reach is texture-bit merging on top of an earlier full write of shadow register 1. The merge has to keep bits 10:9 and replace bits 8:0, and that only shows if register 1 already holds nonzero high bits. The stimulus therefore sweeps all 256 opcodes twice. In the second pass every textured primitive follows the first pass's 0xE1 write, and the output port stalls every third cycle, so the snoop and the stall hold are both exercised together. Transfer packets are checked against an engine model whose busy time changes with the opcode, so the cycle in which `in_ready` returns is pinned for several hold lengths.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  localparam int unsigned OP_W  = 8;
  localparam int unsigned TEX_W = 9;
  localparam int unsigned STAT_W = 13;

  localparam logic [OP_W-1:0] OP_IMG_WRITE = 8'hA0;
  localparam logic [OP_W-1:0] OP_IMG_READ  = 8'hC0;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_DRAIN,
    ST_XSTART,
    ST_XWAIT
  } gpf_state_e;

  // Number of parameter words that follow the first word of a packet.
  function automatic logic [3:0] param_words(input logic [OP_W-1:0] op);
    logic [3:0] n;
    case (op[7:2])
      6'h08:                      n = 4'd3;
      6'h09:                      n = 4'd6;
      6'h0A:                      n = 4'd4;
      6'h0B:                      n = 4'd8;
      6'h0C:                      n = 4'd5;
      6'h0D:                      n = 4'd8;
      6'h0E:                      n = 4'd7;
      6'h0F:                      n = 4'd11;
      6'h10, 6'h11, 6'h18,
      6'h1D, 6'h1F:               n = 4'd2;
      6'h12, 6'h13, 6'h14,
      6'h15, 6'h19:               n = 4'd3;
      6'h16, 6'h17:               n = 4'd4;
      6'h1A, 6'h1C, 6'h1E:        n = 4'd1;
      default:                    n = 4'd0;
    endcase
    if (op == 8'h02 || op == OP_IMG_WRITE || op == OP_IMG_READ) n = 4'd2;
    if (op == 8'h80) n = 4'd3;
    return n;
  endfunction

endpackage

// File: rtl/gpf_len_lut.sv
module gpf_len_lut #(
  parameter int LEN_W = 5
) (
  input  logic [gpf_pkg::OP_W-1:0] op,
  output logic [LEN_W-1:0]         total
);
  assign total = LEN_W'(gpf_pkg::param_words(op)) + LEN_W'(1);
endmodule

// File: rtl/gpf_pkt_buf.sv
module gpf_pkt_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gpf_shadow.sv
module gpf_shadow #(
  parameter int W     = 32,
  parameter int N     = 8,
  parameter int TEX_W = 9,
  localparam int SEL_W = $clog2(N)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [gpf_pkg::OP_W-1:0]      op,
  input  logic [W-1:0]                  word0,
  input  logic                          tex_en,
  input  logic [TEX_W-1:0]              tex_bits,
  output logic [N*W-1:0]                regs_flat,
  output logic [gpf_pkg::STAT_W-1:0]    status
);
  localparam logic [7:0] STORE_BASE = 8'hE0;

  logic store_hit;
  assign store_hit = commit && (op[7:SEL_W] == STORE_BASE[7:SEL_W]);

  for (genvar i = 0; i < N; i++) begin : g_sh
    localparam logic [31:0] RST32 = (32'hE0 + 32'(i)) << 24;
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= W'(RST32);
      end else if (store_hit && op[SEL_W-1:0] == SEL_W'(i)) begin
        r <= word0;
      end else if (i == 1 && commit && tex_en) begin
        r[TEX_W-1:0] <= tex_bits;
      end
    end
    assign regs_flat[i*W +: W] = r;
  end

  assign status = {g_sh[6].r[1:0], g_sh[1].r[10:0]};
endmodule

// File: rtl/gpf_framer.sv
module gpf_framer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int NUM_SH = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_last,
  input  logic                        out_ready,
  output logic                        xfer_start,
  output logic                        xfer_read,
  output logic [DATA_W-1:0]           xfer_pos,
  output logic [DATA_W-1:0]           xfer_size,
  input  logic                        xfer_busy,
  output logic [gpf_pkg::STAT_W-1:0]  status,
  output logic [NUM_SH*DATA_W-1:0]    shadow_regs,
  output logic                        frame_dirty
);
  import gpf_pkg::*;

  gpf_state_e        state;
  logic [IDX_W-1:0]  wr_idx;
  logic [LEN_W-1:0]  rd_idx;
  logic [LEN_W-1:0]  len_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] w0_q;
  logic [TEX_W-1:0]  tex_q;

  logic              accept, first_word, is_final, is_xfer, is_tex, tex_hit, dirty_op, rd_en;
  logic [OP_W-1:0]   cur_op;
  logic [LEN_W-1:0]  lut_len, cur_len;
  logic [IDX_W-1:0]  tex_idx;
  logic [DATA_W-1:0] word0_now;
  logic [TEX_W-1:0]  tex_now;

  assign in_ready   = (state == ST_COLLECT);
  assign accept     = in_valid && in_ready;
  assign first_word = (wr_idx == '0);
  assign cur_op     = first_word ? in_data[DATA_W-1 -: OP_W] : op_q;
  assign cur_len    = first_word ? lut_len : len_q;
  assign is_final   = accept && (LEN_W'(wr_idx) + LEN_W'(1) == cur_len);
  assign is_xfer    = (cur_op == OP_IMG_WRITE) || (cur_op == OP_IMG_READ);
  assign is_tex     = ((cur_op & 8'hF4) == 8'h24) || ((cur_op & 8'hF4) == 8'h34);
  assign tex_idx    = ((cur_op & 8'hF4) == 8'h24) ? IDX_W'(4) : IDX_W'(5);
  assign tex_hit    = accept && is_tex && (wr_idx == tex_idx);
  assign tex_now    = tex_hit ? in_data[TEX_W-1:0] : tex_q;
  assign word0_now  = first_word ? in_data : w0_q;
  assign dirty_op   = (cur_op >= 8'h02) && (cur_op <= 8'hBF);
  assign rd_en      = (state == ST_DRAIN) && (!out_valid || out_ready) && (rd_idx < len_q);

  gpf_len_lut #(.LEN_W(LEN_W)) len_i (
    .op    (in_data[DATA_W-1 -: OP_W]),
    .total (lut_len)
  );

  gpf_pkt_buf #(.W(DATA_W), .DEPTH(DEPTH)) buf_i (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (wr_idx),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_addr (rd_idx[IDX_W-1:0]),
    .rd_data (out_data)
  );

  gpf_shadow #(.W(DATA_W), .N(NUM_SH), .TEX_W(TEX_W)) shadow_i (
    .clk       (clk),
    .rst       (rst),
    .commit    (is_final),
    .op        (cur_op),
    .word0     (word0_now),
    .tex_en    (is_tex),
    .tex_bits  (tex_now),
    .regs_flat (shadow_regs),
    .status    (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_COLLECT;
      wr_idx      <= '0;
      rd_idx      <= '0;
      len_q       <= '0;
      op_q        <= '0;
      w0_q        <= '0;
      tex_q       <= '0;
      out_valid   <= 1'b0;
      out_last    <= 1'b0;
      xfer_start  <= 1'b0;
      xfer_read   <= 1'b0;
      xfer_pos    <= '0;
      xfer_size   <= '0;
      frame_dirty <= 1'b0;
    end else begin
      frame_dirty <= is_final && dirty_op;
      xfer_start  <= 1'b0;
      case (state)
        ST_COLLECT: begin
          if (accept) begin
            if (first_word) begin
              op_q  <= in_data[DATA_W-1 -: OP_W];
              w0_q  <= in_data;
              len_q <= lut_len;
            end
            if (tex_hit) tex_q <= in_data[TEX_W-1:0];
            if (is_xfer && wr_idx == IDX_W'(1)) xfer_pos  <= in_data;
            if (is_xfer && wr_idx == IDX_W'(2)) xfer_size <= in_data;
            if (is_final) begin
              wr_idx <= '0;
              rd_idx <= '0;
              if (is_xfer) begin
                state      <= ST_XSTART;
                xfer_start <= 1'b1;
                xfer_read  <= (cur_op == OP_IMG_READ);
              end else begin
                state <= ST_DRAIN;
              end
            end else begin
              wr_idx <= wr_idx + IDX_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (!out_valid || out_ready) begin
            if (rd_idx < len_q) begin
              out_valid <= 1'b1;
              out_last  <= (rd_idx == len_q - LEN_W'(1));
              rd_idx    <= rd_idx + LEN_W'(1);
            end else begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              state     <= ST_COLLECT;
            end
          end
        end
        ST_XSTART: state <= ST_XWAIT;
        ST_XWAIT:  if (!xfer_busy) state <= ST_COLLECT;
        default:   state <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/gpf_framer_chk.sv
module gpf_framer_chk #(
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [DATA_W-1:0]           out_data,
  input logic                        out_last,
  input logic                        xfer_start,
  input logic                        frame_dirty,
  input logic [gpf_pkg::STAT_W-1:0]  status
);
  assert_hold_while_full_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_stall_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  assert_no_forward_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (!out_valid && !in_ready));

  assert_dirty_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_dirty |=> !frame_dirty);

  assert_status_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(status));
endmodule

bind gpf_framer gpf_framer_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/gpf_framer_tb_top.sv
module gpf_framer_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_last;
  logic          out_ready = 1'b1;
  logic          xfer_start, xfer_read;
  logic [DW-1:0] xfer_pos, xfer_size;
  logic          xfer_busy;
  logic [12:0]   status;
  logic [8*DW-1:0] shadow_regs;
  logic          frame_dirty;

  int checks = 0;
  int fails  = 0;
  int hold_len = 1;
  int eng_cnt = 0;
  logic [31:0] sh [8];

  always #10 clk = ~clk;

  gpf_framer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
    .xfer_busy(xfer_busy), .status(status), .shadow_regs(shadow_regs), .frame_dirty(frame_dirty)
  );

  // Transfer engine model: busy for hold_len cycles after the start strobe.
  always @(posedge clk) begin
    if (rst) eng_cnt <= 0;
    else if (xfer_start) eng_cnt <= hold_len;
    else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
  end
  assign xfer_busy = (eng_cnt != 0);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_params(input int op);
    if (op == 2 || op == 'hA0 || op == 'hC0) return 2;
    if (op == 'h80) return 3;
    if (op >= 'h20 && op <= 'h3F) begin
      case ((op - 'h20) / 4)
        0: return 3;  1: return 6;  2: return 4;  3: return 8;
        4: return 5;  5: return 8;  6: return 7;  default: return 11;
      endcase
    end
    if (op >= 'h40 && op <= 'h47) return 2;
    if (op >= 'h48 && op <= 'h57) return 3;
    if (op >= 'h58 && op <= 'h5F) return 4;
    if (op >= 'h60 && op <= 'h63) return 2;
    if (op >= 'h64 && op <= 'h67) return 3;
    if (op >= 'h68 && op <= 'h6B) return 1;
    if (op >= 'h70 && op <= 'h73) return 1;
    if (op >= 'h74 && op <= 'h77) return 2;
    if (op >= 'h78 && op <= 'h7B) return 1;
    if (op >= 'h7C && op <= 'h7F) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] word_of(input int op, input int k, input int seed);
    logic [31:0] v;
    if (k == 0) begin
      v = 32'(op * 'h1357 + seed * 'h9E3 + 'h5A5);
      return {op[7:0], v[23:0]};
    end
    return 32'(op * 32'h01000193) + 32'(k) * 32'h9E3779B9 + 32'(seed) * 32'h7F4A7C15;
  endfunction

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic check_shadow(input string tag);
    for (int i = 0; i < 8; i++)
      chk(shadow_regs[i*32 +: 32] == sh[i], tag, 64'(shadow_regs[i*32 +: 32]), 64'(sh[i]));
  endtask

  task automatic run_packet(input int op, input int seed, input bit stall);
    logic [31:0] w [12];
    int n;
    bit dirty, xfer, got_last, prev_stall;
    int idx, cyc;
    logic [31:0] prev_data;
    logic [12:0] exp_stat;
    n = 1 + exp_params(op);
    for (int k = 0; k < 12; k++) w[k] = word_of(op, k, seed);
    dirty = (op >= 2 && op < 'hC0);
    xfer  = (op == 'hA0 || op == 'hC0);

    for (int k = 0; k < n; k++) begin
      send_word(w[k]);
      if (k == 0 && n > 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R3 partial packet held, input open",
            64'({in_ready, out_valid}), 64'(2'b10));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;

    // R5 / R6 reference model of the shadow registers
    if (op >= 'hE0 && op <= 'hE7) sh[op - 'hE0] = w[0];
    if ((op & 'hF4) == 'h24) sh[1][8:0] = w[4][8:0];
    if ((op & 'hF4) == 'h34) sh[1][8:0] = w[5][8:0];
    exp_stat = {sh[6][1:0], sh[1][10:0]};

    chk(in_ready == 1'b0, "R3 input closed after final word", 64'(in_ready), 64'(0));
    chk(frame_dirty == dirty, "R8 dirty strobe", 64'(frame_dirty), 64'(dirty));
    chk(status == exp_stat, "R5 R6 R10 status at final-word edge", 64'(status), 64'(exp_stat));
    check_shadow("R5 R6 R10 shadow registers");

    if (xfer) begin
      chk(xfer_start == 1'b1, "R7 start strobe", 64'(xfer_start), 64'(1));
      chk(xfer_read == (op == 'hC0), "R7 direction", 64'(xfer_read), 64'(op == 'hC0));
      chk(xfer_pos == w[1], "R7 position word", 64'(xfer_pos), 64'(w[1]));
      chk(xfer_size == w[2], "R7 size word", 64'(xfer_size), 64'(w[2]));
      for (int j = 1; j <= hold_len + 2; j++) begin
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 transfer packet not forwarded", 64'(out_valid), 64'(0));
        chk(in_ready == (j == hold_len + 2), "R7 input reopens after busy falls",
            64'(in_ready), 64'(j == hold_len + 2));
        if (j == 1) chk(xfer_start == 1'b0 && frame_dirty == 1'b0, "R7 R8 single-cycle strobes",
                        64'({xfer_start, frame_dirty}), 64'(0));
      end
      return;
    end

    @(negedge clk);
    chk(frame_dirty == 1'b0, "R8 dirty lasts one cycle", 64'(frame_dirty), 64'(0));
    idx = 0; cyc = 0; got_last = 1'b0; prev_stall = 1'b0; prev_data = '0;
    while (!got_last && cyc < 200) begin
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R4 word held while stalled",
            64'(out_data), 64'(prev_data));
      prev_stall = 1'b0;
      if (out_valid) begin
        if (out_ready) begin
          chk(out_data == w[idx], "R1 word order", 64'(out_data), 64'(w[idx]));
          chk(out_last == (idx == n - 1), "R1 last flag", 64'(out_last), 64'(idx == n - 1));
          got_last = out_last;
          idx++;
        end else begin
          prev_stall = 1'b1;
          prev_data  = out_data;
        end
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(idx == n, "R2 packet length", 64'(idx), 64'(n));
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R3 input reopens after last word",
        64'({in_ready, out_valid}), 64'(2'b10));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) sh[i] = (32'hE0 + 32'(i)) << 24;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'(1));
    chk(out_valid == 1'b0 && xfer_start == 1'b0 && frame_dirty == 1'b0, "R9 reset strobes",
        64'({out_valid, xfer_start, frame_dirty}), 64'(0));
    chk(status == 13'd0, "R9 reset status", 64'(status), 64'(0));
    check_shadow("R9 reset shadow");

    for (int pass = 0; pass < 2; pass++)
      for (int op = 0; op < 256; op++) begin
        hold_len = 1 + (op % 4) + pass;
        run_packet(op, pass, pass == 1);
      end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule